// File: doc/BRIEF.md
# Packet Convolutional Coder with Block Interleaver and 8-PSK Symbol Mapper

This block is the coding front end of a data service. Payload bits arrive one per cycle on a valid/ready input with start and end markers. Each bit goes through a rate one-half code with constraint length 7. The coded bits are written row by row into a matrix of 8 rows and 12 columns. The matrix is read back column by column in groups of three bits, and each group becomes a Gray-coded 8-PSK phase index from 0 to 7. The index leaves on a valid/ready output that carries its own start and end markers.

Two matrices are used in turn, so one can fill while the other drains. When a packet ends, the block feeds six zero bits into the coder on its own so that the coder returns to the all-zero state. Any positions left over in the final matrix are filled with zeros. A receiver therefore always gets whole matrices of 32 symbols.

Top module: `cc_psk8_coder`

## Requirements
- R1: A bit is taken when `in_valid` and `in_ready` are both high at a rising edge. A symbol is taken when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_sym`, `out_sop` and `out_eop` hold their values.
- R2: For input bit u[n], with u[n-d] the bit d steps earlier, the coder forms A = u[n]^u[n-3]^u[n-4]^u[n-5]^u[n-6] and B = u[n]^u[n-1]^u[n-3]^u[n-4]^u[n-6]. History bits before the start-of-packet bit count as zero.
- R3: Coded bits fill one matrix in order A then B. Coded bit number p of a block (p from 0 to 95) goes to row p/12, column p%12.
- R4: Symbol s of a block (s from 0 to 31) reads positions i = 3s, 3s+1 and 3s+2, with i mapped to row i%8 and column i/8. The first bit read is the MSB of the 3-bit group g.
- R5: `out_sym` is the phase index k that satisfies g = k ^ (k>>1). As a result, neighbouring phases differ in exactly one bit of g.
- R6: After the end-of-packet bit, six zero bits are coded as normal input. `in_ready` stays low during these six bits, and the coder ends in the all-zero state.
- R7: Once the tail bits are coded, every remaining position of the last matrix is zero. A packet of N bits gives ceil(2(N+6)/96) matrices of 32 symbols each.
- R8: `out_sop` is high only on the first symbol of a packet. `out_eop` is high only on the last symbol of a packet.
- R9: At most two full matrices are held. `in_ready` drops when the matrix being written is still waiting to be read. With `out_ready` held low, exactly 96 bits of a long packet are accepted.
- R10: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Block can take an input bit |
| in_bit | input | 1 | Payload bit |
| in_sop | input | 1 | First bit of a packet |
| in_eop | input | 1 | Last bit of a packet |
| out_valid | output | 1 | Symbol present |
| out_ready | input | 1 | Downstream takes the symbol |
| out_sym | output | 3 | 8-PSK phase index |
| out_sop | output | 1 | First symbol of a packet |
| out_eop | output | 1 | Last symbol of a packet |

## Verification
A matrix becomes readable on the clock after the edge that writes its last pair. From then on, one symbol can leave on every edge where `out_ready` is high. An input bit is taken on the same edge that sees `in_ready` high, and `in_ready` depends only on registered state. The bench changes its inputs at the falling edge, a short delay later reads `in_ready` and `out_valid` for the transfer due at the next rising edge, and records a transfer only when both sides of the handshake are high. The back-pressure check lets several hundred cycles pass with the output blocked before it counts the accepted bits.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {W_DATA, W_TAIL, W_PAD} wr_mode_e;

    // 3-bit Gray group (first bit in MSB) to phase index
    function automatic logic [2:0] gray_to_phase(input logic [2:0] g);
        gray_to_phase = {g[2], g[2] ^ g[1], g[2] ^ g[1] ^ g[0]};
    endfunction
endpackage

// File: rtl/cc_conv_enc.sv
module cc_conv_enc #(
    parameter int K = 7,
    parameter logic [K-1:0] G_A = 7'b1111001,
    parameter logic [K-1:0] G_B = 7'b1011011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       clr,
    input  logic       din,
    input  logic       tail_last,
    output logic [1:0] code
);
    localparam int M = K - 1;

    typedef struct packed {
        logic [M-1:0] sr;   // sr[d-1] holds the bit d steps back
    } enc_st_t;

    enc_st_t st_q, st_d;
    logic [K-1:0] win;

    always_comb begin
        st_d = st_q;
        win  = {(clr ? {M{1'b0}} : st_q.sr), din};
        code = {^(win & G_A), ^(win & G_B)};
        if (adv) begin
            st_d.sr = win[M-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the last tail bit leaves the coder in the zero state
    p_flush_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && tail_last) |=> (st_q.sr == '0));
endmodule

// File: rtl/cc_ilv_writer.sv
module cc_ilv_writer
    import cc_pkg::*;
#(
    parameter int NPAIR = 48,
    parameter int TAIL  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_bit,
    input  logic                     in_sop,
    input  logic                     in_eop,
    input  logic                     bank_full,
    output logic                     in_ready,
    output logic                     enc_adv,
    output logic                     enc_clr,
    output logic                     enc_din,
    output logic                     enc_tail_last,
    output logic                     pad,
    output logic                     wr_en,
    output logic [$clog2(NPAIR)-1:0] wr_ptr,
    output logic                     wr_close,
    output logic                     wr_first,
    output logic                     wr_last
);
    localparam int PW = $clog2(NPAIR);
    localparam int TW = $clog2(TAIL) + 1;

    typedef struct packed {
        wr_mode_e      mode;
        logic [PW-1:0] ptr;
        logic [TW-1:0] tcnt;
        logic          sop_seen;
    } wr_st_t;

    wr_st_t st_q, st_d;
    logic   acc;
    logic   ptr_end;
    logic   tail_end;

    always_comb begin
        st_d          = st_q;
        in_ready      = (st_q.mode == W_DATA) && !bank_full;
        acc           = in_valid && in_ready;
        ptr_end       = (st_q.ptr == PW'(NPAIR - 1));
        tail_end      = (st_q.tcnt == TW'(TAIL - 1));
        enc_din       = (st_q.mode == W_DATA) ? in_bit : 1'b0;
        wr_en         = 1'b0;
        enc_adv       = 1'b0;
        enc_clr       = 1'b0;
        enc_tail_last = 1'b0;
        pad           = 1'b0;
        unique case (st_q.mode)
            W_DATA: if (acc) begin
                wr_en   = 1'b1;
                enc_adv = 1'b1;
                enc_clr = in_sop;
                if (in_sop) st_d.sop_seen = 1'b1;
                if (in_eop) begin
                    st_d.mode = W_TAIL;
                    st_d.tcnt = '0;
                end
            end
            W_TAIL: if (!bank_full) begin
                wr_en   = 1'b1;
                enc_adv = 1'b1;
                if (tail_end) begin
                    enc_tail_last = 1'b1;
                    st_d.mode     = ptr_end ? W_DATA : W_PAD;
                end else begin
                    st_d.tcnt = st_q.tcnt + 1'b1;
                end
            end
            W_PAD: if (!bank_full) begin
                wr_en = 1'b1;
                pad   = 1'b1;
                if (ptr_end) st_d.mode = W_DATA;
            end
            default: st_d.mode = W_DATA;
        endcase
        wr_ptr   = st_q.ptr;
        wr_close = wr_en && ptr_end;
        wr_first = st_q.sop_seen || (acc && in_sop);
        wr_last  = (st_q.mode == W_PAD) || ((st_q.mode == W_TAIL) && tail_end);
        if (wr_en)    st_d.ptr      = ptr_end ? '0 : st_q.ptr + 1'b1;
        if (wr_close) st_d.sop_seen = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: W_DATA, default: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cc_ilv_store.sv
module cc_ilv_store #(
    parameter int ROWS = 8,
    parameter int COLS = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [$clog2(ROWS*COLS/2)-1:0]      wr_ptr,
    input  logic [1:0]                          wr_pair,
    input  logic                                wr_close,
    input  logic                                wr_first,
    input  logic                                wr_last,
    output logic                                wb_full,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [2:0]                          out_bits,
    output logic                                out_sop,
    output logic                                out_eop
);
    localparam int NBITS = ROWS * COLS;
    localparam int NSYM  = NBITS / 3;
    localparam int BW    = $clog2(NBITS);
    localparam int SW    = $clog2(NSYM);

    typedef struct packed {
        logic [1:0][NBITS-1:0] mem;
        logic [1:0]            full;
        logic [1:0]            first;
        logic [1:0]            last;
        logic                  wb;
        logic                  rb;
        logic [SW-1:0]         ridx;
    } st_t;

    st_t st_q, st_d;
    logic [BW-1:0] wa;

    always_comb begin
        st_d      = st_q;
        wb_full   = st_q.full[st_q.wb];
        out_valid = st_q.full[st_q.rb];
        for (int j = 0; j < 3; j++) begin
            int i;
            i = 3 * int'(st_q.ridx) + j;
            out_bits[2-j] = st_q.mem[st_q.rb][BW'((i % ROWS) * COLS + i / ROWS)];
        end
        out_sop = st_q.first[st_q.rb] && (st_q.ridx == '0);
        out_eop = st_q.last[st_q.rb] && (st_q.ridx == SW'(NSYM - 1));
        wa = BW'(2 * int'(wr_ptr));
        if (wr_en) begin
            st_d.mem[st_q.wb][wa]        = wr_pair[1];
            st_d.mem[st_q.wb][wa + 1'b1] = wr_pair[0];
        end
        if (wr_close) begin
            st_d.full[st_q.wb]  = 1'b1;
            st_d.first[st_q.wb] = wr_first;
            st_d.last[st_q.wb]  = wr_last;
            st_d.wb             = ~st_q.wb;
        end
        if (out_valid && out_ready) begin
            if (st_q.ridx == SW'(NSYM - 1)) begin
                st_d.ridx          = '0;
                st_d.full[st_q.rb] = 1'b0;
                st_d.rb            = ~st_q.rb;
            end else begin
                st_d.ridx = st_q.ridx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: the writer never touches a matrix that is still waiting to be read
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !st_q.full[st_q.wb]);
    // R1: a stalled symbol keeps its value
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bits) && $stable(out_sop) && $stable(out_eop)));
    // R8: the end marker only comes with a symbol
    p_eop_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_eop |-> out_valid);
endmodule

// File: rtl/cc_psk8_coder.sv
module cc_psk8_coder
    import cc_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 12,
    parameter int K    = 7,
    parameter logic [K-1:0] G_A = 7'b1111001,
    parameter logic [K-1:0] G_B = 7'b1011011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_bit,
    input  logic       in_sop,
    input  logic       in_eop,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [2:0] out_sym,
    output logic       out_sop,
    output logic       out_eop
);
    localparam int NPAIR = ROWS * COLS / 2;
    localparam int PW    = $clog2(NPAIR);

    logic          enc_adv, enc_clr, enc_din, enc_tail_last, pad;
    logic [1:0]    code;
    logic          wr_en, wr_close, wr_first, wr_last, wb_full;
    logic [PW-1:0] wr_ptr;
    logic [2:0]    grp;

    cc_ilv_writer #(.NPAIR(NPAIR), .TAIL(K - 1)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
        .in_sop(in_sop), .in_eop(in_eop), .bank_full(wb_full),
        .in_ready(in_ready), .enc_adv(enc_adv), .enc_clr(enc_clr),
        .enc_din(enc_din), .enc_tail_last(enc_tail_last), .pad(pad),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_close(wr_close),
        .wr_first(wr_first), .wr_last(wr_last)
    );

    cc_conv_enc #(.K(K), .G_A(G_A), .G_B(G_B)) u_enc (
        .clk(clk), .rst_n(rst_n), .adv(enc_adv), .clr(enc_clr),
        .din(enc_din), .tail_last(enc_tail_last), .code(code)
    );

    cc_ilv_store #(.ROWS(ROWS), .COLS(COLS)) u_st (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
        .wr_pair(pad ? 2'b00 : code), .wr_close(wr_close),
        .wr_first(wr_first), .wr_last(wr_last), .wb_full(wb_full),
        .out_valid(out_valid), .out_ready(out_ready), .out_bits(grp),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    assign out_sym = gray_to_phase(grp);

    // R6: no payload bit is taken while the coder is being flushed or padded
    p_tail_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_tail_last || pad) |-> !in_ready);
endmodule

// File: tb/sim_cc_psk8_coder.sv
module sim_cc_psk8_coder;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 8, NC = 12, NB = NR * NC, NS = NB / 3;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_bit = 0, in_sop = 0, in_eop = 0, out_ready = 0;
    logic in_ready, out_valid, out_sop, out_eop;
    logic [2:0] out_sym;

    int n_chk = 0, n_bad = 0, ready_pct = 70, accepted = 0, rx_cnt = 0;
    bit finished = 0;
    logic [4:0]    exp_q[$];
    logic [NB-1:0] blk_q[$];
    logic [NB-1:0] rx_blk;

    cc_psk8_coder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_bit(in_bit), .in_sop(in_sop), .in_eop(in_eop),
        .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
        .out_sop(out_sop), .out_eop(out_eop)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [2:0] to_gray(input logic [2:0] k);
        return k ^ (k >> 1);
    endfunction

    function automatic logic [2:0] phase_of(input logic [2:0] g);
        for (int k = 0; k < 8; k++) if (to_gray(3'(k)) == g) return 3'(k);
        return 3'd0;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Builds the expected symbols of one packet, then drives its bits
    task automatic send_pkt(input int n);
        logic b[$];
        logic c[$];
        logic [6:0] w = '0;
        int nblk;
        for (int k = 0; k < n; k++) b.push_back(1'($urandom % 2));
        // R2 coder, R6 six zero tail bits
        for (int k = 0; k < n + 6; k++) begin
            w = {w[5:0], (k < n) ? b[k] : 1'b0};
            c.push_back(w[0] ^ w[3] ^ w[4] ^ w[5] ^ w[6]);
            c.push_back(w[0] ^ w[1] ^ w[3] ^ w[4] ^ w[6]);
        end
        while (c.size() % NB != 0) c.push_back(1'b0);   // R7 zero padding
        nblk = c.size() / NB;
        for (int bk = 0; bk < nblk; bk++) begin
            logic [NB-1:0] blk;
            for (int p = 0; p < NB; p++) blk[p] = c[bk * NB + p];   // R3 row-major
            blk_q.push_back(blk);
            for (int s = 0; s < NS; s++) begin
                logic [2:0] g;
                for (int j = 0; j < 3; j++) begin
                    int i;
                    i = 3 * s + j;
                    g[2-j] = blk[(i % NR) * NC + i / NR];           // R4 column read
                end
                exp_q.push_back({(bk == 0 && s == 0), (bk == nblk - 1 && s == NS - 1),
                                 phase_of(g)});
            end
        end
        for (int k = 0; k < n; k++) begin
            repeat ($urandom % 3) @(negedge clk);
            in_valid = 1; in_bit = b[k]; in_sop = (k == 0); in_eop = (k == n - 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            accepted++;
            in_valid = 0; in_sop = 0; in_eop = 0;
        end
    endtask

    // Output side: random ready, compare, and undo the interleaving
    initial begin
        forever begin
            @(negedge clk);
            out_ready = ($urandom % 100) < ready_pct;
            #1;
            if (rst_n && out_valid && out_ready) begin
                logic [4:0] e;
                logic [2:0] g;
                if (exp_q.size() == 0) begin
                    check(0, "R1 unexpected symbol", out_sym, -1);
                end else begin
                    e = exp_q.pop_front();
                    check(out_sym == e[2:0], "R2 R3 R4 R5 R6 R7 symbol", out_sym, e[2:0]);
                    check(out_sop == e[4], "R8 out_sop", out_sop, e[4]);
                    check(out_eop == e[3], "R8 out_eop", out_eop, e[3]);
                end
                g = to_gray(out_sym);
                for (int j = 0; j < 3; j++) begin
                    int i;
                    i = 3 * rx_cnt + j;
                    rx_blk[(i % NR) * NC + i / NR] = g[2-j];
                end
                rx_cnt++;
                if (rx_cnt == NS) begin
                    rx_cnt = 0;
                    if (blk_q.size() != 0) begin
                        logic [NB-1:0] eb;
                        eb = blk_q.pop_front();
                        check(rx_blk == eb, "R3 R4 deinterleaved block", int'(rx_blk[31:0]), int'(eb[31:0]));
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(out_valid == 0, "R10 out_valid after reset", out_valid, 0);
        check(in_ready == 1, "R10 in_ready after reset", in_ready, 1);
        for (int k = 0; k < 8; k++)   // R5 neighbouring phases differ in one bit
            check($countones(to_gray(3'(k)) ^ to_gray(3'(k + 1))) == 1, "R5 gray adjacency", k, k);

        send_pkt(1);     // shortest packet, heavy padding
        send_pkt(42);    // tail closes the block exactly, no pad
        send_pkt(45);    // tail crosses into a second block
        send_pkt(2);
        ready_pct = 20;
        send_pkt(150);   // slow reader
        ready_pct = 100;
        send_pkt(90);    // fast reader

        // R9 back-pressure: both matrices fill, then the input stalls
        wait (exp_q.size() == 0);
        repeat (40) @(negedge clk);
        ready_pct = 0;
        accepted = 0;
        fork
            send_pkt(200);
            begin
                repeat (500) @(negedge clk);
                #1;
                check(accepted == 96, "R9 bits taken while blocked", accepted, 96);
                check(in_ready == 0, "R9 in_ready while blocked", in_ready, 0);
                check(out_valid == 1, "R9 out_valid while blocked", out_valid, 1);
                ready_pct = 60;
            end
        join

        for (int p = 0; p < 12; p++) begin
            ready_pct = 30 + int'($urandom % 70);
            send_pkt(1 + int'($urandom % 120));
        end

        wait (exp_q.size() == 0);
        repeat (20) @(negedge clk);
        #1;
        check(out_valid == 0, "R1 idle after drain", out_valid, 0);
        summary();
    end
endmodule